// File: doc/BRIEF.md
# Fill-Level Clock Steering Buffer

This block is a 32-byte elastic store sitting between a byte-wide payload producer and a consumer that drains bytes to a serial output. The number of bytes held is compared every cycle against two programmable thresholds. The result drives two level outputs that ask an external oscillator to speed up or slow down. The buffer's occupancy therefore acts as the phase comparator of a clock recovery loop. A third output pulses whenever either steering level changes, so a downstream loop filter only needs to sample on that pulse.

The consumer sees the oldest stored byte at all times, and pops it with a read strobe. A write into a full store or a read from an empty store is a fault. It sets a flag that stays set until the block is reset. Dropping the enable input flushes the store and releases both steering requests. This gives a restart that clears all stored data without resetting the block.

Top module: `fifo_rate_steer`

## Requirements
- R1: The store holds up to 32 bytes and returns them in write order. `rd_data_o` presents the oldest byte combinationally while the store is non-empty. An accepted read strobe pops that byte. `fill_o` gives the stored count (0..32) and is updated at the clock edge that samples the strobes.
- R2: When a read and a write are both accepted in one cycle, the count is unchanged. When the store is full, a write paired with a read is accepted and sets no fault.
- R3: `inc_o` is high in the cycle after the count was strictly greater than `hi_mark_i` while enabled.
- R4: `dec_o` is high in the cycle after the count was strictly less than `lo_mark_i` while enabled.
- R5: When the count lies between the two marks, with either end included, both steering outputs are low in the following cycle.
- R6: `upd_o` is high for exactly those cycles in which `inc_o` or `dec_o` differs from its value in the previous cycle.
- R7: A write to a full store without a read in the same cycle is dropped. The count stays at 32 and `corrupt_o` is set.
- R8: A read from an empty store shows `rd_data_o` = 0, leaves the count at 0 and sets `corrupt_o`. A write in the same cycle is still stored.
- R9: `corrupt_o` is sticky: once set, it stays high until `rst_ni` is asserted.
- R10: While `en_i` is low, the next clock leaves the store empty and both steering outputs low. Strobes are ignored and cannot set `corrupt_o`.
- R11: After reset, `fill_o`, `inc_o`, `dec_o`, `upd_o`, `corrupt_o` and `rd_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low flushes the store and clears steering |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Byte to store |
| rd_i | input | 1 | Read strobe, pops oldest byte |
| rd_data_o | output | 8 | Oldest stored byte, 0 when empty |
| hi_mark_i | input | 5 | Upper threshold |
| lo_mark_i | input | 5 | Lower threshold |
| inc_o | output | 1 | Request faster output clock |
| dec_o | output | 1 | Request slower output clock |
| upd_o | output | 1 | Steering level changed this cycle |
| fill_o | output | 6 | Stored byte count |
| corrupt_o | output | 1 | Sticky overflow/underflow flag |

## Verification
A miscounted pointer or count shows up in two ways. The byte presented on `rd_data_o` differs from the write order on the next read. `fill_o` drifts from the number of accepted strobes at the very next edge. A wrong threshold comparison appears one cycle later as a wrong steering level together with a missing or stray `upd_o` pulse. A missed fault leaves `corrupt_o` low in the cycle after the offending strobe, and it then stays wrong for the rest of the run.

// File: rtl/fifo_rate_steer_pkg.sv
package fifo_rate_steer_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
  } steer_t;
endpackage

// File: rtl/frs_store.sv
module frs_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic empty, full, rd_acc, wr_acc;

  assign empty  = (count_q == '0);
  assign full   = (count_q == CW'(DEPTH));
  assign rd_acc = en_i && rd_i && !empty;
  // full store still takes a write when a read frees a slot
  assign wr_acc = en_i && wr_i && (!full || rd_acc);
  assign ovf_o  = en_i && wr_i && !wr_acc;
  assign unf_o  = en_i && rd_i && empty;
  assign rd_data_o = empty ? '0 : mem_q[rptr_q];
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (!en_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_acc) wptr_q <= wptr_q + AW'(1);
      if (rd_acc) rptr_q <= rptr_q + AW'(1);
      count_q <= count_q + CW'(wr_acc) - CW'(rd_acc);
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_acc) mem_q[wptr_q] <= wr_data_i;
  end
endmodule

// File: rtl/frs_steer.sv
module frs_steer
  import fifo_rate_steer_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] hi_mark_i,
  input  logic [AW-1:0] lo_mark_i,
  output steer_t        steer_o,
  output logic          upd_o
);
  steer_t steer_q, steer_d;
  logic   upd_q;

  always_comb begin
    steer_d.inc = en_i && (count_i > CW'(hi_mark_i));
    steer_d.dec = en_i && (count_i < CW'(lo_mark_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      steer_q <= steer_d;
      upd_q   <= (steer_d != steer_q);
    end
  end

  assign steer_o = steer_q;
  assign upd_o   = upd_q;
endmodule

// File: rtl/fifo_rate_steer.sv
module fifo_rate_steer
  import fifo_rate_steer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] hi_mark_i,
  input  logic [AW-1:0] lo_mark_i,
  output logic          inc_o,
  output logic          dec_o,
  output logic          upd_o,
  output logic [CW-1:0] fill_o,
  output logic          corrupt_o
);
  logic [CW-1:0] count;
  logic ovf, unf, corrupt_q;
  steer_t steer;

  frs_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni, .en_i, .wr_i, .wr_data_i, .rd_i,
    .rd_data_o, .count_o(count), .ovf_o(ovf), .unf_o(unf)
  );

  frs_steer #(.DEPTH(DEPTH)) u_steer (
    .clk_i, .rst_ni, .en_i, .count_i(count),
    .hi_mark_i, .lo_mark_i, .steer_o(steer), .upd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         corrupt_q <= 1'b0;
    else if (ovf || unf) corrupt_q <= 1'b1;
  end

  assign inc_o     = steer.inc;
  assign dec_o     = steer.dec;
  assign fill_o    = count;
  assign corrupt_o = corrupt_q;
endmodule

// File: rtl/fifo_rate_steer_chk.sv
module fifo_rate_steer_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic [DW-1:0] rd_data_o,
  input logic          inc_o,
  input logic          dec_o,
  input logic          upd_o,
  input logic [CW-1:0] fill_o,
  input logic          corrupt_o
);
  assert_fill_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= CW'(DEPTH));

  assert_overflow_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && !rd_i && fill_o == CW'(DEPTH)) |=> (corrupt_o && fill_o == CW'(DEPTH)));

  assert_underflow_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && fill_o == '0) |-> (rd_data_o == '0));

  assert_underflow_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && fill_o == '0) |=> corrupt_o);

  assert_corrupt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corrupt_o |=> corrupt_o);

  assert_upd_on_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (inc_o != $past(inc_o) || dec_o != $past(dec_o)));

  assert_disable_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (fill_o == '0 && !inc_o && !dec_o));

  assert_disable_no_fault_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !corrupt_o) |=> !corrupt_o);
endmodule

bind fifo_rate_steer fifo_rate_steer_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .en_i, .wr_i, .rd_i, .rd_data_o,
  .inc_o, .dec_o, .upd_o, .fill_o, .corrupt_o
);

// File: tb/fifo_rate_steer_tb.sv
module fifo_rate_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wd = '0;
  logic [4:0] hi = '0, lo = '0;
  logic [7:0] rdata;
  logic inc, dec, upd, cor;
  logic [5:0] fill;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic inc_m, dec_m, upd_m, cor_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_rate_steer u_dut (
    .clk_i(clk), .rst_ni, .en_i(en), .wr_i(wr), .wr_data_i(wd), .rd_i(rd),
    .rd_data_o(rdata), .hi_mark_i(hi), .lo_mark_i(lo),
    .inc_o(inc), .dec_o(dec), .upd_o(upd), .fill_o(fill), .corrupt_o(cor)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; en = 0; wr = 0; rd = 0;
    q.delete(); inc_m = 0; dec_m = 0; upd_m = 0; cor_m = 0;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 fill", fill, 0); chk("R11 inc", inc, 0); chk("R11 dec", dec, 0);
    chk("R11 upd", upd, 0); chk("R11 corrupt", cor, 0); chk("R11 rdata", rdata, 0);
    rst_ni = 1'b1;
  endtask

  function automatic int sz();
    return q.size();
  endfunction

  task automatic step(input logic e, input logic w, input logic [7:0] d, input logic r,
                      input logic [4:0] h, input logic [4:0] l, input string tag);
    logic ni, nd, ra, wa;
    int n;
    @(negedge clk);
    en = e; wr = w; wd = d; rd = r; hi = h; lo = l;
    #1;
    chk({tag, " R1 rdata"}, rdata, (sz() > 0) ? int'(q[0]) : 0);
    n  = sz();
    ni = e && (n > int'(h));
    nd = e && (n < int'(l));
    upd_m = (ni != inc_m) || (nd != dec_m);
    inc_m = ni; dec_m = nd;
    if (!e) q.delete();
    else begin
      ra = r && n > 0;
      wa = w && (n < DEPTH || ra);
      if ((r && n == 0) || (w && !wa)) cor_m = 1;
      if (ra) void'(q.pop_front());
      if (wa) q.push_back(d);
    end
    @(posedge clk); #1;
    chk({tag, " R1 fill"}, fill, sz());
    chk({tag, " R3 inc"}, inc, inc_m);
    chk({tag, " R4 dec"}, dec, dec_m);
    chk({tag, " R6 upd"}, upd, upd_m);
    chk({tag, " R9 corrupt"}, cor, cor_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(1234);
    do_reset();
    // R1 fill to capacity with marks 20/10
    for (int i = 0; i < DEPTH; i++) step(1, 1, 8'(i + 3), 0, 20, 10, "fill R1 R3 R4 R5");
    // R2 full with simultaneous read and write
    step(1, 1, 8'hAA, 1, 20, 10, "R2 full rw");
    chk("R2 no fault", cor, 0);
    // R7 overflow
    step(1, 1, 8'h55, 0, 20, 10, "R7 overflow");
    chk("R7 count held", fill, 32);
    // drain, ordering R1
    for (int i = 0; i < DEPTH; i++) step(1, 0, 8'h0, 1, 20, 10, "drain R1");
    // R8 underflow with write
    step(1, 1, 8'h77, 1, 20, 10, "R8 underflow");
    chk("R8 write kept", fill, 1);
    step(1, 0, 8'h0, 1, 20, 10, "R8 pop");
    // R10 disable flush without fault
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 1, 8'(i), 0, 2, 1, "R10 pre");
    step(0, 1, 8'h9, 1, 2, 1, "R10 off");
    step(0, 0, 8'h0, 1, 2, 1, "R10 off read");
    chk("R10 corrupt", cor, 0);
    chk("R10 fill", fill, 0);
    // R5 equal-to-mark boundary
    for (int i = 0; i < 4; i++) step(1, 1, 8'(i), 0, 4, 4, "R5 edge");
    step(1, 0, 8'h0, 0, 4, 4, "R5 at mark");
    chk("R5 inc low", inc, 0); chk("R5 dec low", dec, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic e, w, r;
      e = ($urandom_range(0, 31) != 0);
      w = ($urandom_range(0, 99) < 52);
      r = ($urandom_range(0, 99) < 48);
      if (i % 700 == 0) do_reset();
      step(e, w, 8'($urandom), r, 5'($urandom_range(10, 24)), 5'($urandom_range(4, 14)), "rand");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule